// File: doc/BRIEF.md
# Delayed Read Completion Master Engine

This engine turns the entry at the head of a delayed-transaction queue into a read on the far bus. It starts a read only when a head entry is present and no earlier posted write is still waiting. The address and command are latched at that moment and stay fixed until the entry completes. It requests the bus, presents one address phase and then takes target responses one clock at a time. Each returned dword goes to the read-data queue that faces the other interface, one dword per clock, with no master wait states.

When the target retries and no data has moved yet, the engine requests the bus again and repeats the read. Every address phase counts as one attempt in a wide counter. A new head entry clears that counter. When the configured number of attempts has been used up, the entry completes with an error and a system-error pulse is raised. The active-low error pin follows that pulse only when its enable is set. A master or target abort ends the entry at once with an error status, and a system error is not raised for an abort.

Arbitration is reduced to a request/grant pair. Target behaviour is reduced to a per-clock response code that comes with the data.

Top module: `dly_rd_master`

## Requirements
- R1: A new read begins (bus_req_o rises from idle) only when head_valid_i is high and pw_pending_i is low. While pw_pending_i is high, bus_req_o stays low.
- R2: bus_addr_o and bus_cmd_o are latched when the read begins. They do not change across every attempt of that entry, even if the head inputs change.
- R3: In every data phase, bus_be_n_o is 4'b0000 for a prefetchable entry (head_pref_i=1). For a non-prefetchable entry it equals the byte enables that were latched at the start.
- R4: tgt_rsp_i code 3 (retry) with no dword transferred in the current attempt makes the engine request the bus again and issue another address phase.
- R5: Each data response (code 1 = data, code 2 = data with stop) in a data phase gives exactly one rdq_wr_o pulse one clock later. rdq_data_o carries that dword, and dwords stay in arrival order.
- R6: A non-prefetchable read ends after 1 dword and a prefetchable read ends after PREF_DW dwords (master termination). Code 2, or a retry after data, ends it earlier. After any dword has transferred, no further attempt is made.
- R7: Suppose an attempt is retried with no data and the attempt count has reached attempt_limit_i (33 bits, so 2^32 can be set). The entry then completes with head_err_o=1, and sys_err_o pulses high in that same completion cycle.
- R8: serr_no goes low for the same single cycle as sys_err_o, and only if serr_en_i was high when the limit was reached.
- R9: Code 4 (master abort) or code 5 (target abort) completes the entry with head_err_o=1. Neither raises sys_err_o or starts another attempt.
- R10: The attempt count is cleared when each new entry begins, so each entry gets the full attempt budget.
- R11: After reset, bus_req_o, head_done_o, rdq_wr_o and sys_err_o are low and serr_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_valid_i | input | 1 | Head entry of the delayed queue is present |
| head_addr_i | input | AW | Captured read address |
| head_cmd_i | input | 4 | Captured read command |
| head_be_n_i | input | BEW | Captured byte enables, active low |
| head_pref_i | input | 1 | Entry is prefetchable |
| pw_pending_i | input | 1 | Earlier posted writes not yet delivered |
| head_done_o | output | 1 | One-cycle completion pulse; pops the head entry |
| head_err_o | output | 1 | Completion carries an error status |
| attempt_limit_i | input | CNT_W | Maximum number of attempts |
| serr_en_i | input | 1 | Enable for the system-error pin |
| sys_err_o | output | 1 | System-error pulse on attempt exhaustion |
| serr_no | output | 1 | System-error pin, active low |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_valid_o | output | 1 | Address phase in this cycle |
| bus_addr_o | output | AW | Read address on the far bus |
| bus_cmd_o | output | 4 | Read command on the far bus |
| bus_dphase_o | output | 1 | Data phase; a target response is taken this cycle |
| bus_be_n_o | output | BEW | Byte enables in data phases, active low |
| tgt_rsp_i | input | 3 | 0 wait, 1 data, 2 data+stop, 3 retry/stop, 4 master abort, 5 target abort |
| tgt_data_i | input | DW | Read dword from the target |
| rdq_wr_o | output | 1 | Write strobe into the read-data queue |
| rdq_data_o | output | DW | Dword written to the read-data queue |

## Verification
Some properties are checked on every cycle. A read never starts without a present head entry and drained posted writes. The address and command hold steady while the engine is busy. Prefetchable data phases drive all byte enables. Queue writes only follow data phases. The system-error pulse and pin only appear together with an error completion, and no request follows a completion. Other behaviour shows up only in the bench scenarios: attempt counts under retry sequences, burst lengths per prefetch mode, exhaustion at a small and at a 2^32 limit, the enable gating on the pin, abort handling, and the counter clearing between entries.

// File: rtl/dly_rd_pkg.sv
package dly_rd_pkg;

  typedef enum logic [2:0] {
    RSP_NONE      = 3'd0,
    RSP_DATA      = 3'd1,
    RSP_DATA_STOP = 3'd2,
    RSP_RETRY     = 3'd3,
    RSP_MABORT    = 3'd4,
    RSP_TABORT    = 3'd5
  } rsp_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_DONE
  } state_e;

endpackage

// File: rtl/dly_rd_req_latch.sv
module dly_rd_req_latch #(
  parameter int AW  = 32,
  parameter int BEW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [3:0]     cmd_i,
  input  logic [BEW-1:0] be_n_i,
  input  logic           pref_i,
  output logic [AW-1:0]  addr_o,
  output logic [3:0]     cmd_o,
  output logic [BEW-1:0] be_n_o,
  output logic           pref_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cmd_o  <= '0;
      be_n_o <= '1;
      pref_o <= 1'b0;
    end else if (load_i) begin
      addr_o <= addr_i;
      cmd_o  <= cmd_i;
      be_n_o <= be_n_i;
      pref_o <= pref_i;
    end
  end

endmodule

// File: rtl/dly_rd_be_sel.sv
module dly_rd_be_sel #(
  parameter int BEW = 4
) (
  input  logic           pref_i,
  input  logic [BEW-1:0] be_n_i,
  output logic [BEW-1:0] be_n_o
);

  // prefetchable: every lane enabled (active low)
  for (genvar g = 0; g < BEW; g++) begin : g_lane
    assign be_n_o[g] = pref_i ? 1'b0 : be_n_i[g];
  end

endmodule

// File: rtl/dly_rd_attempt_ctr.sv
module dly_rd_attempt_ctr #(
  parameter int CNT_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && ~&cnt_q)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q >= limit_i);

endmodule

// File: rtl/dly_rd_master.sv
module dly_rd_master
  import dly_rd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int BEW     = 4,
  parameter int CNT_W   = 33,
  parameter int PREF_DW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_valid_i,
  input  logic [AW-1:0]    head_addr_i,
  input  logic [3:0]       head_cmd_i,
  input  logic [BEW-1:0]   head_be_n_i,
  input  logic             head_pref_i,
  input  logic             pw_pending_i,
  output logic             head_done_o,
  output logic             head_err_o,
  input  logic [CNT_W-1:0] attempt_limit_i,
  input  logic             serr_en_i,
  output logic             sys_err_o,
  output logic             serr_no,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic             bus_addr_valid_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [3:0]       bus_cmd_o,
  output logic             bus_dphase_o,
  output logic [BEW-1:0]   bus_be_n_o,
  input  logic [2:0]       tgt_rsp_i,
  input  logic [DW-1:0]    tgt_data_i,
  output logic             rdq_wr_o,
  output logic [DW-1:0]    rdq_data_o
);

  localparam int DWC_W = $clog2(PREF_DW + 1);

  state_e           state_q, state_d;
  rsp_e             rsp;
  logic             start, busy, limit_hit, pref_q;
  logic [BEW-1:0]   be_n_q;
  logic [DWC_W-1:0] dw_cnt_q, dw_nxt, burst_len;
  logic             wr, fin_err, lim_err;
  logic             err_q, sys_q, pin_q;

  assign rsp   = rsp_e'(tgt_rsp_i);
  assign start = (state_q == S_IDLE) && head_valid_i && !pw_pending_i;
  assign busy  = (state_q != S_IDLE);

  dly_rd_req_latch #(.AW(AW), .BEW(BEW)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .addr_i (head_addr_i),
    .cmd_i  (head_cmd_i),
    .be_n_i (head_be_n_i),
    .pref_i (head_pref_i),
    .addr_o (bus_addr_o),
    .cmd_o  (bus_cmd_o),
    .be_n_o (be_n_q),
    .pref_o (pref_q)
  );

  dly_rd_be_sel #(.BEW(BEW)) u_be_sel (
    .pref_i (pref_q),
    .be_n_i (be_n_q),
    .be_n_o (bus_be_n_o)
  );

  dly_rd_attempt_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .inc_i   (state_q == S_ADDR),
    .limit_i (attempt_limit_i),
    .hit_o   (limit_hit)
  );

  assign burst_len = pref_q ? DWC_W'(PREF_DW) : DWC_W'(1);
  assign dw_nxt    = dw_cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    wr      = 1'b0;
    fin_err = 1'b0;
    lim_err = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) state_d = S_REQ;
      S_REQ:  if (bus_gnt_i) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: begin
        unique case (rsp)
          RSP_DATA: begin
            wr = 1'b1;
            if (dw_nxt == burst_len) state_d = S_DONE;
          end
          RSP_DATA_STOP: begin
            wr      = 1'b1;
            state_d = S_DONE;
          end
          RSP_RETRY: begin
            if (dw_cnt_q != '0) begin
              state_d = S_DONE;
            end else if (limit_hit) begin
              state_d = S_DONE;
              fin_err = 1'b1;
              lim_err = 1'b1;
            end else begin
              state_d = S_REQ;
            end
          end
          RSP_MABORT, RSP_TABORT: begin
            state_d = S_DONE;
            fin_err = 1'b1;
          end
          default: ;
        endcase
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      dw_cnt_q   <= '0;
      err_q      <= 1'b0;
      sys_q      <= 1'b0;
      pin_q      <= 1'b0;
      rdq_wr_o   <= 1'b0;
      rdq_data_o <= '0;
    end else begin
      state_q  <= state_d;
      sys_q    <= lim_err;
      pin_q    <= lim_err & serr_en_i;
      rdq_wr_o <= wr;
      if (wr) rdq_data_o <= tgt_data_i;
      if (state_q == S_DATA) err_q <= fin_err;
      if (state_q == S_ADDR) dw_cnt_q <= '0;
      else if (wr)           dw_cnt_q <= dw_nxt;
    end
  end

  assign bus_req_o        = (state_q == S_REQ);
  assign bus_addr_valid_o = (state_q == S_ADDR);
  assign bus_dphase_o     = (state_q == S_DATA);
  assign head_done_o      = (state_q == S_DONE);
  assign head_err_o       = head_done_o & err_q;
  assign sys_err_o        = sys_q;
  assign serr_no          = ~pin_q;

  // R1
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(head_valid_i && !pw_pending_i));

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(bus_addr_o) && $stable(bus_cmd_o)));

  // R3
  pref_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_dphase_o && pref_q) |-> (bus_be_n_o == '0));

  // R5
  rdq_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdq_wr_o |-> $past(bus_dphase_o));

  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_done_o |=> !bus_req_o);

  // R7
  sys_err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_o |-> (head_done_o && head_err_o));

  // R8
  serr_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> sys_err_o);

endmodule

// File: tb/dly_rd_master_tb_top.sv
module dly_rd_master_tb_top;

  localparam int AW = 32, DW = 32, BEW = 4, CNT_W = 33, PREF_DW = 4;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             head_valid_i = 0, head_pref_i = 0, pw_pending_i = 0;
  logic [AW-1:0]    head_addr_i = '0;
  logic [3:0]       head_cmd_i = '0;
  logic [BEW-1:0]   head_be_n_i = '1;
  logic             head_done_o, head_err_o;
  logic [CNT_W-1:0] attempt_limit_i = 33'd16;
  logic             serr_en_i = 0, sys_err_o, serr_no;
  logic             bus_req_o, bus_gnt_i = 0, bus_addr_valid_o, bus_dphase_o;
  logic [AW-1:0]    bus_addr_o;
  logic [3:0]       bus_cmd_o;
  logic [BEW-1:0]   bus_be_n_o;
  logic [2:0]       tgt_rsp_i = 3'd0;
  logic [DW-1:0]    tgt_data_i = '0;
  logic             rdq_wr_o;
  logic [DW-1:0]    rdq_data_o;

  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  dly_rd_master #(.AW(AW), .DW(DW), .BEW(BEW), .CNT_W(CNT_W), .PREF_DW(PREF_DW)) dut_i (.*);

  // kind: 0 data then stop, 1 endless data (master ends), 2 master abort, 3 target abort
  typedef struct packed {
    logic       pref;
    logic [3:0] be_n;
    logic [7:0] retries;
    logic [1:0] kind;
    logic [3:0] ndw;
    logic [7:0] lim;
    logic       en;
    logic [3:0] e_dw;
    logic       e_err;
    logic       e_sys;
    logic       e_pin;
    logic [7:0] e_att;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 4'h5, 8'd0, 2'd1, 4'd0, 8'd16, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 8'd1},
    '{1'b1, 4'hE, 8'd0, 2'd1, 4'd0, 8'd16, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 8'd1},
    '{1'b1, 4'h0, 8'd2, 2'd0, 4'd2, 8'd16, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 8'd3},
    '{1'b0, 4'hC, 8'd3, 2'd1, 4'd0, 8'd3,  1'b1, 4'd0, 1'b1, 1'b1, 1'b1, 8'd3},
    '{1'b1, 4'h3, 8'd5, 2'd1, 4'd0, 8'd2,  1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd2},
    '{1'b0, 4'h9, 8'd0, 2'd2, 4'd0, 8'd16, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 8'd1},
    '{1'b1, 4'h7, 8'd1, 2'd3, 4'd0, 8'd16, 1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 8'd2},
    '{1'b1, 4'hA, 8'd0, 2'd0, 4'd1, 8'd16, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 8'd1},
    '{1'b0, 4'h6, 8'd1, 2'd0, 4'd3, 8'd2,  1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic run_case(input vec_t v, input logic [CNT_W-1:0] lim, input int pw_hold,
                          input logic [AW-1:0] addr);
    int rl, dl, sent, got, att, data_bad, be_bad, addr_bad, req_early, cyc;
    bit sys_seen, pin_seen, err, done, scrambled;
    rl = v.retries; dl = v.ndw; sent = 0; got = 0; att = 0;
    data_bad = 0; be_bad = 0; addr_bad = 0; req_early = 0;
    sys_seen = 0; pin_seen = 0; err = 0; done = 0; scrambled = 0;
    @(negedge clk_i);
    head_valid_i = 1; head_addr_i = addr; head_cmd_i = 4'h6;
    head_be_n_i = v.be_n; head_pref_i = v.pref;
    attempt_limit_i = lim; serr_en_i = v.en;
    pw_pending_i = (pw_hold > 0);
    for (int i = 0; i < pw_hold; i++) begin
      @(negedge clk_i);
      if (bus_req_o) req_early++;
    end
    if (pw_hold > 0) begin
      chk(req_early == 0, "R1 request while posted writes pending", req_early, 0);
      pw_pending_i = 0;
      @(negedge clk_i);
      chk(bus_req_o == 1'b1, "R1 request after drain", bus_req_o, 1);
    end
    for (cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk_i);
      if (bus_addr_valid_o) begin
        att++;
        if (bus_addr_o != addr || bus_cmd_o != 4'h6) addr_bad++;
      end
      if (bus_dphase_o && bus_be_n_o != (v.pref ? 4'h0 : v.be_n)) be_bad++;
      if (rdq_wr_o) begin
        if (rdq_data_o != 32'hA000_0000 + got) data_bad++;
        got++;
      end
      if (sys_err_o) sys_seen = 1;
      if (!serr_no) pin_seen = 1;
      if (head_done_o) begin
        done = 1;
        err = head_err_o;
        head_valid_i = 0;
      end
      if (bus_req_o && !scrambled) begin
        scrambled = 1;
        head_addr_i = ~addr; head_cmd_i = 4'h9;
        head_be_n_i = ~v.be_n; head_pref_i = ~v.pref;
      end
      bus_gnt_i = bus_req_o;
      tgt_rsp_i = 3'd0;
      if (bus_dphase_o) begin
        if (rl > 0) begin
          tgt_rsp_i = 3'd3; rl--;
        end else begin
          case (v.kind)
            2'd2: tgt_rsp_i = 3'd4;
            2'd3: tgt_rsp_i = 3'd5;
            2'd1: tgt_rsp_i = 3'd1;
            default: begin
              tgt_rsp_i = (dl <= 1) ? 3'd2 : 3'd1;
              dl--;
            end
          endcase
          if (tgt_rsp_i == 3'd1 || tgt_rsp_i == 3'd2) begin
            tgt_data_i = 32'hA000_0000 + sent;
            sent++;
          end
        end
      end
    end
    tgt_rsp_i = 3'd0; bus_gnt_i = 0;
    chk(done, "R6 entry completes", done, 1);
    chk(got == v.e_dw, "R6 dwords per read", got, v.e_dw);
    chk(err == v.e_err, "R9 completion error status", err, v.e_err);
    chk(sys_seen == v.e_sys, "R7 system error pulse", sys_seen, v.e_sys);
    chk(pin_seen == v.e_pin, "R8 system error pin gating", pin_seen, v.e_pin);
    chk(att == v.e_att, "R4 attempts issued", att, v.e_att);
    chk(addr_bad == 0, "R2 address/command held", addr_bad, 0);
    chk(be_bad == 0, "R3 byte enables", be_bad, 0);
    chk(data_bad == 0, "R5 queue data order", data_bad, 0);
    @(negedge clk_i);
    chk(!bus_req_o, "R6 no further attempt", bus_req_o, 0);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!bus_req_o && !head_done_o && !rdq_wr_o && !sys_err_o && serr_no,
        "R11 reset outputs", {bus_req_o, head_done_o, rdq_wr_o, sys_err_o, serr_no}, 1);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!bus_req_o, "R11 idle without head", bus_req_o, 0);

    foreach (VEC[k]) run_case(VEC[k], CNT_W'(VEC[k].lim), 0, 32'h1000_0000 + 32'(k) * 32'h40);

    // R1 drain gate
    run_case(VEC[1], 33'd16, 5, 32'h2000_0100);

    // R7 limit of 2^32 is representable: a few retries do not exhaust it
    v = '{1'b1, 4'h0, 8'd3, 2'd1, 4'd0, 8'd0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, 8'd4};
    run_case(v, 33'h1_0000_0000, 0, 32'h3000_0000);

    // R10 count restarts per entry: two entries each using the whole budget
    v = '{1'b0, 4'h1, 8'd2, 2'd1, 4'd0, 8'd3, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'd3};
    run_case(v, 33'd3, 0, 32'h4000_0000);
    run_case(v, 33'd3, 0, 32'h4000_0080);

    summary();
  end

endmodule